// File: doc/BRIEF.md
# Serial Link Status and Command Register

This block is the eight-bit status and command register that sits between a host CPU and a bit-oriented serial link engine. Both sides write it. The CPU can load the whole byte or change a single bit by index, and it may change any bit. The engine raises and lowers individual flags through set and clear masks, but only on the bits it is allowed to touch. When both sides write the same bit in the same cycle, the block settles the conflict.

Besides holding the byte, the block drives the signals that act on the rest of the link logic:
- a gated write strobe for the receive buffer;
- the select between a ready and a not-ready supervisory reply;
- the decoded link mode;
- the interrupt request;
- the active-low request-to-send pin.

Every output except the register itself is combinational from the stored bits and the current control inputs. A write takes effect at the next rising clock edge. There is no stream interface. All pins are plain control and status signals with no handshake.

Top module: `sdlc_stat_cmd_reg`

## Requirements
- R1: While reset is asserted, and after it is released, the register reads 0x40 (only bit 6, receive-buffer-empty, set). irq_o is 0 and rts_n_o is 1.
- R2: A CPU byte write loads cpu_wdata_i into all eight bits at the next clock edge, unless a conflict rule below overrides a bit.
- R3: A CPU single-bit write sets bit cpu_bit_sel_i to cpu_bit_val_i and leaves the other bits unchanged. The bit positions are: 7 transmit-full, 6 receive-empty, 5 request-to-send, 4 interrupt flag, 3 overrun, 2 optional-poll enable, 1 mode, 0 receive-protect.
- R4: Engine permissions are as follows:
  - Bits 7, 6, 3 and 2 may be set and cleared by the engine.
  - Bit 4 may only be set by the engine.
  - Bit 1 may only be cleared by the engine.
  - Bit 0 ignores the engine.
  - If eng_set_i and eng_clr_i both hit one bit, the set wins.
- R5: The engine can set or clear bit 5 only while the link is in auto mode (addr_mode_sel_i=0 and bit 1=1). Otherwise its writes to bit 5 are ignored.
- R6: When the CPU and the engine write the same bit in one cycle, the CPU value wins. The exception is bit 4: an engine set beats a CPU clear.
- R7: mode_o = {addr_mode_sel_i, bit 1}. The encodings are 00 flexible, 01 auto, 10 non-addressed, 11 addressed.
- R8: rxbuf_we_o equals eng_rxbuf_we_i while bit 0 is clear, and is 0 while bit 0 is set.
- R9: rnr_sel_o is 1 (not-ready reply) only in auto mode with bit 0 set. Otherwise it is 0 (ready reply).
- R10: irq_o is high exactly while bit 4 is set.
- R11: rts_n_o is the inverse of bit 5 when loop_mode_i=0. It is held at 1 when loop_mode_i=1.
- R12: If a byte write and a single-bit write arrive in the same cycle, the byte is loaded and then the addressed bit takes cpu_bit_val_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr_byte_i | input | 1 | CPU whole-byte write strobe |
| cpu_wdata_i | input | 8 | CPU byte write data |
| cpu_wr_bit_i | input | 1 | CPU single-bit write strobe |
| cpu_bit_sel_i | input | 3 | Index of the bit for a single-bit write |
| cpu_bit_val_i | input | 1 | Value for a single-bit write |
| eng_set_i | input | 8 | Engine set mask |
| eng_clr_i | input | 8 | Engine clear mask |
| addr_mode_sel_i | input | 1 | Selects the addressed/non-addressed meaning of bit 1 |
| loop_mode_i | input | 1 | Loop configuration; forces rts_n_o high |
| eng_rxbuf_we_i | input | 1 | Engine request to write the receive buffer |
| stat_o | output | 8 | Current register contents |
| mode_o | output | 2 | Decoded link mode |
| rxbuf_we_o | output | 1 | Gated receive-buffer write strobe |
| rnr_sel_o | output | 1 | 1 selects the not-ready reply, 0 the ready reply |
| irq_o | output | 1 | Interrupt request |
| rts_n_o | output | 1 | Active-low request-to-send pin |

## Verification
The assertions check several rules on every cycle:
- bit 0 never changes without a CPU write;
- the engine never raises bit 1;
- bit 5 stays still outside auto mode unless the CPU writes it;
- an engine interrupt set always lands;
- a plain byte write loads exactly;
- the receive strobe never passes while protection is on.

The bench scenarios show the rest:
- the full permission matrix, under mixed set and clear masks;
- the CPU-over-engine conflict outcomes;
- the mode decode as the select input changes;
- the reply select;
- the pin behaviour in and out of loop mode;
- the byte-plus-bit merge;
- the reset value, both at start-up and after a reset in mid-run.

// File: rtl/sdlc_stat_pkg.sv
package sdlc_stat_pkg;
  localparam int STAT_W = 8;
  localparam int SEL_W  = $clog2(STAT_W);

  // Bit positions: neighbours decode these
  localparam int B_PROT  = 0;
  localparam int B_MODE  = 1;
  localparam int B_OPOLL = 2;
  localparam int B_OVR   = 3;
  localparam int B_IRQ   = 4;
  localparam int B_RTS   = 5;
  localparam int B_RXE   = 6;
  localparam int B_TXF   = 7;

  // Engine permission masks, one bit per register bit
  localparam logic [STAT_W-1:0] ENG_SET_MASK  = 8'hFC;
  localparam logic [STAT_W-1:0] ENG_CLR_MASK  = 8'hEE;
  // Bits whose engine access depends on auto mode
  localparam logic [STAT_W-1:0] AUTO_GATE_MASK = 8'h20;
  // Bits where a CPU write beats the engine
  localparam logic [STAT_W-1:0] CPU_PRIO_MASK = 8'hEF;
  localparam logic [STAT_W-1:0] RESET_VAL     = 8'h40;

  typedef enum logic [1:0] {
    MODE_FLEX    = 2'b00,
    MODE_AUTO    = 2'b01,
    MODE_NONADDR = 2'b10,
    MODE_ADDR    = 2'b11
  } link_mode_e;
endpackage

// File: rtl/stat_cpu_wr_decode.sv
module stat_cpu_wr_decode
  import sdlc_stat_pkg::*;
(
  input  logic              wr_byte,
  input  logic [STAT_W-1:0] wdata,
  input  logic              wr_bit,
  input  logic [SEL_W-1:0]  bit_sel,
  input  logic              bit_val,
  output logic [STAT_W-1:0] we,
  output logic [STAT_W-1:0] d
);
  always_comb begin
    we = wr_byte ? {STAT_W{1'b1}} : '0;
    d  = wr_byte ? wdata : '0;
    if (wr_bit) begin
      we[bit_sel] = 1'b1;
      d[bit_sel]  = bit_val;
    end
  end
endmodule

// File: rtl/stat_bit_cell.sv
module stat_bit_cell #(
  parameter bit SET_OK   = 1'b1,
  parameter bit CLR_OK   = 1'b1,
  parameter bit CPU_PRIO = 1'b1,
  parameter bit GATED    = 1'b0,
  parameter bit RST_VAL  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_we,
  input  logic cpu_d,
  input  logic eng_set,
  input  logic eng_clr,
  input  logic auto_mode,
  output logic q
);
  logic gate;
  logic eng_s;
  logic eng_c;

  assign gate  = GATED ? auto_mode : 1'b1;
  assign eng_s = eng_set & SET_OK & gate;
  assign eng_c = eng_clr & CLR_OK & gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST_VAL;
    end else if (cpu_we) begin
      if (!CPU_PRIO && eng_s) q <= 1'b1;
      else                    q <= cpu_d;
    end else if (eng_s) begin
      q <= 1'b1;
    end else if (eng_c) begin
      q <= 1'b0;
    end
  end
endmodule

// File: rtl/stat_out_decode.sv
module stat_out_decode
  import sdlc_stat_pkg::*;
(
  input  logic       prot_bit,
  input  logic       mode_bit,
  input  logic       irq_bit,
  input  logic       rts_bit,
  input  logic       addr_sel,
  input  logic       loop_mode,
  input  logic       rx_we_req,
  output link_mode_e mode,
  output logic       auto_mode,
  output logic       rxbuf_we,
  output logic       rnr_sel,
  output logic       irq,
  output logic       rts_n
);
  assign mode      = link_mode_e'({addr_sel, mode_bit});
  assign auto_mode = (mode == MODE_AUTO);
  assign rxbuf_we  = rx_we_req & ~prot_bit;
  assign rnr_sel   = auto_mode & prot_bit;
  assign irq       = irq_bit;
  assign rts_n     = loop_mode ? 1'b1 : ~rts_bit;
endmodule

// File: rtl/sdlc_stat_cmd_reg.sv
module sdlc_stat_cmd_reg
  import sdlc_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr_byte_i,
  input  logic [STAT_W-1:0] cpu_wdata_i,
  input  logic              cpu_wr_bit_i,
  input  logic [SEL_W-1:0]  cpu_bit_sel_i,
  input  logic              cpu_bit_val_i,
  input  logic [STAT_W-1:0] eng_set_i,
  input  logic [STAT_W-1:0] eng_clr_i,
  input  logic              addr_mode_sel_i,
  input  logic              loop_mode_i,
  input  logic              eng_rxbuf_we_i,
  output logic [STAT_W-1:0] stat_o,
  output logic [1:0]        mode_o,
  output logic              rxbuf_we_o,
  output logic              rnr_sel_o,
  output logic              irq_o,
  output logic              rts_n_o
);
  logic [STAT_W-1:0] cpu_we;
  logic [STAT_W-1:0] cpu_d;
  logic [STAT_W-1:0] stat_q;
  logic              auto_mode;
  link_mode_e        mode;

  stat_cpu_wr_decode u_wr_dec (
    .wr_byte (cpu_wr_byte_i),
    .wdata   (cpu_wdata_i),
    .wr_bit  (cpu_wr_bit_i),
    .bit_sel (cpu_bit_sel_i),
    .bit_val (cpu_bit_val_i),
    .we      (cpu_we),
    .d       (cpu_d)
  );

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    stat_bit_cell #(
      .SET_OK   (ENG_SET_MASK[i]),
      .CLR_OK   (ENG_CLR_MASK[i]),
      .CPU_PRIO (CPU_PRIO_MASK[i]),
      .GATED    (AUTO_GATE_MASK[i]),
      .RST_VAL  (RESET_VAL[i])
    ) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_we    (cpu_we[i]),
      .cpu_d     (cpu_d[i]),
      .eng_set   (eng_set_i[i]),
      .eng_clr   (eng_clr_i[i]),
      .auto_mode (auto_mode),
      .q         (stat_q[i])
    );
  end

  stat_out_decode u_out_dec (
    .prot_bit  (stat_q[B_PROT]),
    .mode_bit  (stat_q[B_MODE]),
    .irq_bit   (stat_q[B_IRQ]),
    .rts_bit   (stat_q[B_RTS]),
    .addr_sel  (addr_mode_sel_i),
    .loop_mode (loop_mode_i),
    .rx_we_req (eng_rxbuf_we_i),
    .mode      (mode),
    .auto_mode (auto_mode),
    .rxbuf_we  (rxbuf_we_o),
    .rnr_sel   (rnr_sel_o),
    .irq       (irq_o),
    .rts_n     (rts_n_o)
  );

  assign stat_o = stat_q;
  assign mode_o = mode;

  // R4: protect bit moves only on a CPU write
  p_prot_cpu_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_we[B_PROT] |=> stat_q[B_PROT] == $past(stat_q[B_PROT]));

  // R4: engine can never raise the mode bit
  p_mode_no_eng_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_we[B_MODE] |=> !(stat_q[B_MODE] && !$past(stat_q[B_MODE])));

  // R5: RTS bit untouched by engine outside auto mode
  p_rts_auto_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_we[B_RTS] && !auto_mode) |=> stat_q[B_RTS] == $past(stat_q[B_RTS]));

  // R6: an engine interrupt set is never lost
  p_irq_not_lost_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_set_i[B_IRQ] |=> irq_o);

  // R2: plain byte write loads exactly
  p_byte_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_byte_i && !cpu_wr_bit_i && !eng_set_i[B_IRQ]) |=> stat_o == $past(cpu_wdata_i));

  // R8: no receive-buffer write while protected
  p_rx_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rxbuf_we_o |-> (eng_rxbuf_we_i && !stat_o[B_PROT]));
endmodule

// File: tb/sdlc_stat_cmd_reg_tb_top.sv
module sdlc_stat_cmd_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_wr_byte_i = 1'b0;
  logic [7:0] cpu_wdata_i = '0;
  logic       cpu_wr_bit_i = 1'b0;
  logic [2:0] cpu_bit_sel_i = '0;
  logic       cpu_bit_val_i = 1'b0;
  logic [7:0] eng_set_i = '0;
  logic [7:0] eng_clr_i = '0;
  logic       addr_mode_sel_i = 1'b0;
  logic       loop_mode_i = 1'b0;
  logic       eng_rxbuf_we_i = 1'b0;
  logic [7:0] stat_o;
  logic [1:0] mode_o;
  logic       rxbuf_we_o, rnr_sel_o, irq_o, rts_n_o;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  sdlc_stat_cmd_reg dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_wr_byte_i(cpu_wr_byte_i), .cpu_wdata_i(cpu_wdata_i),
    .cpu_wr_bit_i(cpu_wr_bit_i), .cpu_bit_sel_i(cpu_bit_sel_i),
    .cpu_bit_val_i(cpu_bit_val_i), .eng_set_i(eng_set_i), .eng_clr_i(eng_clr_i),
    .addr_mode_sel_i(addr_mode_sel_i), .loop_mode_i(loop_mode_i),
    .eng_rxbuf_we_i(eng_rxbuf_we_i), .stat_o(stat_o), .mode_o(mode_o),
    .rxbuf_we_o(rxbuf_we_o), .rnr_sel_o(rnr_sel_o), .irq_o(irq_o), .rts_n_o(rts_n_o)
  );

  typedef struct packed {
    logic       bw;
    logic [7:0] wd;
    logic       tw;
    logic [2:0] ti;
    logic       tv;
    logic [7:0] es;
    logic [7:0] ec;
    logic       nb;
    logic       lp;
    logic       rw;
    logic [7:0] xs;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b1, 8'h00, 1'b0, 3'd0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 4'd2},
    '{1'b1, 8'h02, 1'b0, 3'd0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 8'h02, 4'd2},
    '{1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 8'h20, 8'h00, 1'b0, 1'b0, 1'b0, 8'h22, 4'd5},
    '{1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b1, 8'hFE, 4'd4},
    '{1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b0, 8'h10, 4'd4},
    '{1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 8'h20, 8'h00, 1'b0, 1'b0, 1'b0, 8'h10, 4'd5},
    '{1'b0, 8'h00, 1'b1, 3'd0, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 8'h11, 4'd3},
    '{1'b0, 8'h00, 1'b1, 3'd1, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 8'h13, 4'd3},
    '{1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 8'h13, 4'd7},
    '{1'b1, 8'h00, 1'b0, 3'd0, 1'b0, 8'h10, 8'h00, 1'b0, 1'b0, 1'b0, 8'h10, 4'd6},
    '{1'b0, 8'h00, 1'b1, 3'd4, 1'b0, 8'h10, 8'h00, 1'b0, 1'b0, 1'b0, 8'h10, 4'd6},
    '{1'b0, 8'h00, 1'b1, 3'd4, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 4'd10},
    '{1'b1, 8'h08, 1'b0, 3'd0, 1'b0, 8'h00, 8'h08, 1'b0, 1'b0, 1'b0, 8'h08, 4'd6},
    '{1'b0, 8'h00, 1'b1, 3'd3, 1'b0, 8'h08, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 4'd6},
    '{1'b1, 8'h22, 1'b1, 3'd5, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 8'h02, 4'd12},
    '{1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 8'h24, 8'h04, 1'b0, 1'b0, 1'b0, 8'h26, 4'd4},
    '{1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 8'h26, 4'd11},
    '{1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 8'h00, 8'h02, 1'b0, 1'b0, 1'b0, 8'h24, 4'd4},
    '{1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 8'h03, 8'h00, 1'b0, 1'b0, 1'b1, 8'h24, 4'd4},
    '{1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 8'h00, 8'h20, 1'b0, 1'b0, 1'b0, 8'h24, 4'd5}
  };

  function automatic string rtag(input logic [3:0] n);
    case (n)
      4'd1:  return "R1";
      4'd2:  return "R2";
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      4'd10: return "R10";
      4'd11: return "R11";
      4'd12: return "R12";
      default: return "R?";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    cpu_wr_byte_i = 1'b0; cpu_wdata_i = '0; cpu_wr_bit_i = 1'b0;
    cpu_bit_sel_i = '0; cpu_bit_val_i = 1'b0; eng_set_i = '0; eng_clr_i = '0;
    addr_mode_sel_i = 1'b0; loop_mode_i = 1'b0; eng_rxbuf_we_i = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk);
    // R1: values during reset
    chk("R1 stat in reset", stat_o, 8'h40);
    chk("R1 irq in reset", {7'd0, irq_o}, 8'h00);
    chk("R1 rts_n in reset", {7'd0, rts_n_o}, 8'h01);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 stat after release", stat_o, 8'h40);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      cpu_wr_byte_i = VECS[k].bw; cpu_wdata_i = VECS[k].wd;
      cpu_wr_bit_i = VECS[k].tw; cpu_bit_sel_i = VECS[k].ti;
      cpu_bit_val_i = VECS[k].tv; eng_set_i = VECS[k].es; eng_clr_i = VECS[k].ec;
      addr_mode_sel_i = VECS[k].nb; loop_mode_i = VECS[k].lp;
      eng_rxbuf_we_i = VECS[k].rw;
      @(posedge clk);
      #1;
      chk($sformatf("%s stat vec%0d", rtag(VECS[k].rq), k), stat_o, VECS[k].xs);
      chk($sformatf("R7 mode vec%0d", k), {6'd0, mode_o}, {6'd0, VECS[k].nb, VECS[k].xs[1]});
      chk($sformatf("R8 rxbuf_we vec%0d", k), {7'd0, rxbuf_we_o},
          {7'd0, VECS[k].rw & ~VECS[k].xs[0]});
      chk($sformatf("R9 rnr_sel vec%0d", k), {7'd0, rnr_sel_o},
          {7'd0, ~VECS[k].nb & VECS[k].xs[1] & VECS[k].xs[0]});
      chk($sformatf("R10 irq vec%0d", k), {7'd0, irq_o}, {7'd0, VECS[k].xs[4]});
      chk($sformatf("R11 rts_n vec%0d", k), {7'd0, rts_n_o},
          {7'd0, VECS[k].lp | ~VECS[k].xs[5]});
    end

    // R9: protected in non-auto mode selects ready reply
    @(negedge clk);
    idle_inputs();
    cpu_wr_byte_i = 1'b1; cpu_wdata_i = 8'h01;
    @(negedge clk);
    idle_inputs();
    chk("R9 rnr off outside auto", {7'd0, rnr_sel_o}, 8'h00);
    cpu_wr_bit_i = 1'b1; cpu_bit_sel_i = 3'd1; cpu_bit_val_i = 1'b1;
    @(negedge clk);
    idle_inputs();
    chk("R9 rnr on in auto with protect", {7'd0, rnr_sel_o}, 8'h01);

    // R1: mid-run reset returns to reset value
    cpu_wr_byte_i = 1'b1; cpu_wdata_i = 8'hBF;
    @(negedge clk);
    idle_inputs();
    chk("R2 load before reset", stat_o, 8'hBF);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset value", stat_o, 8'h40);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rts_n after reset", {7'd0, rts_n_o}, 8'h01);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule